// File: doc/BRIEF.md
# Data-Side Memory Window Decoder

This block sits on the path between a processor's 32-bit data load/store bus and a word-wide memory built in fabric. An 8-bit window register names one 16 MB region of the 4 GB address space. When the control register enables decoding and the top byte of a request's address equals the window register, the access is claimed. The block then drives a 22-bit word address, the write data and the byte enables to the memory. Any other access passes by untouched.

Memory transactions are paced by a clock-enable divider on the single clock. A 3-bit ratio code in the control register sets the divider. Load data comes back on a response strobe with a latency that software selects. In the short mode the memory's read data goes straight to the response register. In the long mode it first lands in a holding register, which adds one cycle. A busy output, which can also be read in the control register, covers each claimed access from acceptance to completion.

The processor presents word addresses: `req_addr` carries byte-address bits 31..2. The register port selects the control register with `cfg_sel` = 0 and the window register with `cfg_sel` = 1. Reads through this port return their data one cycle after the select is presented.

Top module: `dwin_decoder`

## Requirements
- R1: After a synchronous reset the control and window registers read 0x00. `busy`, `mem_en`, `req_hit` and `rsp_valid` are 0, and `req_ready` is 1. The block is therefore disabled, with short latency and ratio code 0.
- R2: Control register layout (LSB = bit 0): bit 0 enable, bit 1 long-latency select, bit 2 busy (read-only, write ignored), bits 4:3 reserved (always read 0), bits 7:5 ratio code. Writing 0xFF while idle reads back 0xE3.
- R3: An accepted request is a hit only when the enable bit is 1 and `req_addr[29:22]` (byte-address bits 31:24) equals the window register. This includes the first and last words of the 16 MB region.
- R4: A request that misses, or any request while the enable bit is 0, gives no `mem_en` pulse, no `req_hit` pulse and no busy cycle.
- R5: For a hit, `mem_en` is high for exactly one cycle. `mem_addr` equals `req_addr[21:0]`. On writes, `mem_we` is 1, `mem_wdata` equals the request data and `mem_be` equals the request byte enables unchanged.
- R6: For a hit read, `rsp_valid` pulses for one cycle and `rsp_rdata` carries the addressed word. With the latency bit at 0, this pulse comes 2 cycles after the `mem_en` cycle; with it at 1, 3 cycles after.
- R7: `busy` rises on the cycle after a hit is accepted. It stays high until the `rsp_valid` cycle of a read, where it is low, or until the cycle after `mem_en` of a write. `req_hit` pulses on the first busy cycle. At ratio 1, busy therefore lasts 2 cycles for a write, 3 for a short read and 4 for a long read.
- R8: Ratio codes 0, 1, 2, 3 give divide ratios 1, 2, 3, 4, and codes 4 to 7 give ratio 1. `mem_en` only rises on divider ticks, which recur every ratio cycles. Back-to-back writes then recur every ceil(3/ratio)·ratio cycles, and back-to-back long reads every ceil(5/ratio)·ratio cycles.
- R9: `req_ready` equals not busy. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 30 | Word address (byte-address bits 31..2) |
| req_we | input | 1 | 1 = store, 0 = load |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Store data |
| req_hit | output | 1 | One-cycle pulse: last accepted request was claimed |
| rsp_valid | output | 1 | Load data strobe |
| rsp_rdata | output | 32 | Load data |
| mem_en | output | 1 | Memory enable |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Memory byte enables |
| mem_addr | output | 22 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = control, 1 = window |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (registered) |
| busy | output | 1 | Claimed access in progress |

## Verification
Stores and loads are aimed at the window's first word, its last word and a middle word, and also just outside both ends and with decoding switched off. This separates a correct top-byte compare from an off-by-one or an ignored enable. A partial byte-enable store followed by a load shows whether the enables reach memory untouched. The same load is issued in both latency modes, which exposes a missing or doubled holding stage. Back-to-back stores and long loads are run under ratio codes 0, 1, 2, 3 and 5. Their pulse spacing forms a distinct pair for each ratio, so any misdecoded code shows up.

// File: rtl/dwin_pkg.sv
`timescale 1ns/1ps
package dwin_pkg;

  localparam int CODE_W = 3;
  localparam int CNT_W  = 2;

  // control register field positions (the busy bit is composed on read)
  localparam int CTL_EN    = 0;
  localparam int CTL_SLOW  = 1;
  localparam int CTL_BUSY  = 2;
  localparam int CTL_RLO   = 5;
  localparam logic [7:0] CTL_WMASK = 8'hE3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEND,
    ST_ISSUE,
    ST_CAPT,
    ST_HOLD
  } xfer_state_t;

  // divide ratio minus one; codes above 3 fall back to ratio 1
  function automatic logic [CNT_W-1:0] ratio_lim(input logic [CODE_W-1:0] code);
    if (code[CODE_W-1]) return '0;
    return code[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/dwin_regs.sv
`timescale 1ns/1ps
module dwin_regs
  import dwin_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              busy,
  output logic              en,
  output logic              slow,
  output logic [CODE_W-1:0] code,
  output logic [WIN_W-1:0]  window
);

  logic [7:0]       ctl_q;
  logic [WIN_W-1:0] win_q;
  logic [7:0]       ctl_view;
  logic [7:0]       win_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      win_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) win_q <= cfg_wdata[WIN_W-1:0];
      else         ctl_q <= cfg_wdata & CTL_WMASK;
    end
  end

  always_comb begin
    ctl_view           = ctl_q & CTL_WMASK;
    ctl_view[CTL_BUSY] = busy;
    win_view           = '0;
    win_view[WIN_W-1:0] = win_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= cfg_sel ? win_view : ctl_view;
  end

  assign en     = ctl_q[CTL_EN];
  assign slow   = ctl_q[CTL_SLOW];
  assign code   = ctl_q[CTL_RLO +: CODE_W];
  assign window = win_q;

endmodule

// File: rtl/dwin_pace.sv
`timescale 1ns/1ps
module dwin_pace
  import dwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim  = ratio_lim(code);
  assign tick = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/dwin_xfer.sv
`timescale 1ns/1ps
module dwin_xfer
  import dwin_pkg::*;
#(
  parameter int AW    = 30,
  parameter int DW    = 32,
  parameter int WIN_W = 8,
  localparam int BEW  = DW / 8,
  localparam int MAW  = AW - WIN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             slow,
  input  logic [WIN_W-1:0] window,
  input  logic             tick,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_we,
  input  logic [BEW-1:0]   req_be,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_hit,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             mem_en,
  output logic             mem_we,
  output logic [BEW-1:0]   mem_be,
  output logic [MAW-1:0]   mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy
);

  xfer_state_t state_q;
  logic        we_q;
  logic        slow_q;
  logic [DW-1:0] hold_q;
  logic        claim;

  assign claim     = req_valid && (state_q == ST_IDLE) && en &&
                     (req_addr[AW-1 -: WIN_W] == window);
  assign busy      = (state_q != ST_IDLE);
  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      slow_q    <= 1'b0;
      hold_q    <= '0;
      req_hit   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      req_hit   <= 1'b0;
      rsp_valid <= 1'b0;
      mem_en    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (claim) begin
            mem_addr  <= req_addr[MAW-1:0];
            mem_be    <= req_be;
            mem_wdata <= req_wdata;
            we_q      <= req_we;
            slow_q    <= slow;
            req_hit   <= 1'b1;
            state_q   <= ST_PEND;
          end
        end
        ST_PEND: begin
          if (tick) begin
            mem_en  <= 1'b1;
            mem_we  <= we_q;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          mem_we  <= 1'b0;
          state_q <= we_q ? ST_IDLE : ST_CAPT;
        end
        ST_CAPT: begin
          if (slow_q) begin
            hold_q  <= mem_rdata;
            state_q <= ST_HOLD;
          end else begin
            rsp_rdata <= mem_rdata;
            rsp_valid <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          rsp_rdata <= hold_q;
          rsp_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dwin_decoder.sv
`timescale 1ns/1ps
module dwin_decoder
  import dwin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_W  = 8,
  localparam int WLSB  = $clog2(DATA_W / 8),
  localparam int AW    = ADDR_W - WLSB,
  localparam int MAW   = AW - WIN_W,
  localparam int BEW   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_we,
  input  logic [BEW-1:0]    req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_hit,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [BEW-1:0]    mem_be,
  output logic [MAW-1:0]    mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              busy
);

  logic              ctrl_en;
  logic              ctrl_slow;
  logic [CODE_W-1:0] ctrl_code;
  logic [WIN_W-1:0]  win;
  logic              tick;

  dwin_regs #(.WIN_W(WIN_W)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .en(ctrl_en), .slow(ctrl_slow), .code(ctrl_code), .window(win)
  );

  dwin_pace u_pace (
    .clk(clk), .rst(rst), .code(ctrl_code), .tick(tick)
  );

  dwin_xfer #(.AW(AW), .DW(DATA_W), .WIN_W(WIN_W)) u_xfer (
    .clk(clk), .rst(rst),
    .en(ctrl_en), .slow(ctrl_slow), .window(win), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata), .req_hit(req_hit),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy)
  );

endmodule

// File: rtl/dwin_checker.sv
`timescale 1ns/1ps
module dwin_checker (
  input logic clk,
  input logic rst,
  input logic mem_en,
  input logic busy,
  input logic req_hit,
  input logic rsp_valid,
  input logic ctrl_en
);

  a_r5_en_single: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);

  a_r6_rsp_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r6_rsp_ends_busy: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !busy);

  a_r7_hit_marks_busy: assert property (@(posedge clk) disable iff (rst)
    req_hit |-> busy);

  a_r7_en_inside_busy: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> busy);

  a_r4_hit_needs_enable: assert property (@(posedge clk) disable iff (rst)
    req_hit |-> $past(ctrl_en));

endmodule

bind dwin_decoder dwin_checker u_chk (
  .clk(clk), .rst(rst), .mem_en(mem_en), .busy(busy),
  .req_hit(req_hit), .rsp_valid(rsp_valid), .ctrl_en(ctrl_en)
);

// File: tb/test_dwin_decoder.sv
`timescale 1ns/1ps
module test_dwin_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [29:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_hit;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_en;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [21:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        busy;

  always #4 clk = ~clk;

  dwin_decoder i_dwin_decoder (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // fabric memory model: one-cycle read, byte-lane writes
  logic [31:0] bmem [0:63];
  initial for (int i = 0; i < 64; i++) bmem[i] = '0;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_addr[5:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= bmem[mem_addr[5:0]];
      end
    end
  end

  // observation at falling edges
  int cyc = 0, en_cnt = 0, hit_cnt = 0, busy_cnt = 0, rsp_cnt = 0;
  int en_cyc = 0, prev_en_cyc = 0, rsp_cyc = 0;
  logic [21:0] o_addr; logic [3:0] o_be; logic [31:0] o_wdata, o_rdata; logic o_we;
  always @(negedge clk) begin
    cyc++;
    if (mem_en) begin
      en_cnt++; prev_en_cyc = en_cyc; en_cyc = cyc;
      o_addr = mem_addr; o_be = mem_be; o_wdata = mem_wdata; o_we = mem_we;
    end
    if (req_hit) hit_cnt++;
    if (busy) busy_cnt++;
    if (rsp_valid) begin rsp_cnt++; rsp_cyc = cyc; o_rdata = rsp_rdata; end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [7:0] d);
    @(negedge clk); cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input bit sel, output logic [7:0] d);
    @(negedge clk); cfg_sel = sel;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic [31:0] baddr, input bit we, input logic [3:0] be,
                        input logic [31:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = baddr[31:2]; req_we = we; req_be = be; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    wait_idle();
  endtask

  function automatic int exp_iv(input int base, input int r);
    return ((base + r - 1) / r) * r;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check(busy == 0 && req_ready == 1, "R1 busy/ready", busy, 0);
    check(en_cnt == 0 && hit_cnt == 0 && rsp_cnt == 0, "R1 no activity", en_cnt, 0);
    cfg_read(0, d); check(d == 8'h00, "R1 control", d, 0);
    cfg_read(1, d); check(d == 8'h00, "R1 window", d, 0);
  endtask

  task automatic t_fields();
    logic [7:0] d;
    cfg_write(0, 8'hFF);
    cfg_read(0, d); check(d == 8'hE3, "R2 reserved/busy bits", d, 8'hE3);
    cfg_write(0, 8'h00);
    cfg_read(0, d); check(d == 8'h00, "R2 clear", d, 0);
  endtask

  task automatic t_disabled();
    int e0 = en_cnt, h0 = hit_cnt, b0 = busy_cnt;
    cfg_write(1, 8'h40);
    access(32'h4000_0010, 1, 4'hF, 32'h1111_1111);
    repeat (6) @(negedge clk);
    check(en_cnt == e0 && hit_cnt == h0 && busy_cnt == b0, "R4 disabled no claim", en_cnt - e0, 0);
  endtask

  task automatic t_miss();
    int e0, h0, b0;
    cfg_write(0, 8'h01);
    e0 = en_cnt; h0 = hit_cnt; b0 = busy_cnt;
    access(32'h4100_0000, 1, 4'hF, 32'h2);
    access(32'h3FFF_FFFC, 0, 4'hF, 32'h0);
    check(en_cnt == e0 && hit_cnt == h0 && busy_cnt == b0, "R3 R4 outside window", en_cnt - e0, 0);
  endtask

  task automatic t_write();
    int e0 = en_cnt, h0 = hit_cnt, b0 = busy_cnt;
    access(32'h40AB_CDE8, 1, 4'b0101, 32'hDEAD_BEEF);
    check(en_cnt == e0 + 1, "R5 one enable", en_cnt - e0, 1);
    check(hit_cnt == h0 + 1, "R7 hit pulse", hit_cnt - h0, 1);
    check(o_addr == 22'h2A_F37A, "R5 word address", o_addr, 22'h2AF37A);
    check(o_we == 1 && o_be == 4'b0101 && o_wdata == 32'hDEAD_BEEF, "R5 write fields", o_be, 4'b0101);
    check(busy_cnt - b0 == 2, "R7 write busy length", busy_cnt - b0, 2);
  endtask

  task automatic t_edges();
    int e0 = en_cnt;
    access(32'h40FF_FFFC, 1, 4'hF, 32'hCAFE_0001);
    check(en_cnt == e0 + 1 && o_addr == 22'h3F_FFFF, "R3 last word", o_addr, 22'h3FFFFF);
    access(32'h4000_0000, 1, 4'hF, 32'hCAFE_0002);
    check(en_cnt == e0 + 2 && o_addr == 22'h0, "R3 first word", o_addr, 0);
  endtask

  task automatic t_read(input bit slow_mode);
    int r0, b0, lat;
    cfg_write(0, slow_mode ? 8'h03 : 8'h01);
    access(32'h4000_0020, 1, 4'hF, 32'h1234_5678);
    r0 = rsp_cnt; b0 = busy_cnt;
    access(32'h4000_0020, 0, 4'hF, 32'h0);
    lat = rsp_cyc - en_cyc;
    check(rsp_cnt == r0 + 1 && o_rdata == 32'h1234_5678, "R6 read data", o_rdata, 32'h12345678);
    check(lat == (slow_mode ? 3 : 2), "R6 latency", lat, slow_mode ? 3 : 2);
    check(busy_cnt - b0 == (slow_mode ? 4 : 3), "R7 read busy length", busy_cnt - b0, slow_mode ? 4 : 3);
    access(32'h40AB_CDE8, 0, 4'hF, 32'h0);
    check(o_rdata == 32'h00AD_00EF, "R5 byte lanes kept", o_rdata, 32'h00AD00EF);
  endtask

  task automatic t_pace(input int code, input int ratio);
    int e0, iv;
    for (int k = 0; k < 2; k++) begin
      cfg_write(0, 8'((code << 5) | (k ? 3 : 1)));
      @(negedge clk);
      e0 = en_cnt;
      req_addr = 30'h1000_0004; req_we = (k == 0); req_be = 4'hF; req_wdata = 32'h5; req_valid = 1'b1;
      while (en_cnt < e0 + 3) @(negedge clk);
      req_valid = 1'b0;
      iv = en_cyc - prev_en_cyc;
      check(iv == exp_iv(k ? 5 : 3, ratio), $sformatf("R8 code %0d spacing", code), iv,
            exp_iv(k ? 5 : 3, ratio));
      wait_idle();
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_disabled();
    t_miss();
    t_write();
    t_edges();
    t_read(0);
    t_read(1);
    t_pace(0, 1);
    t_pace(1, 2);
    t_pace(2, 3);
    t_pace(3, 4);
    t_pace(5, 1);
    check(req_ready == 1, "R9 idle ready", req_ready, 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule